// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Predictor

This block sits beside the fetch stage of a deep in-order pipeline. Every fetch address is presented to it, and in the same cycle it reports whether a known direct branch or jump lives at that address, the address the branch goes to, and whether fetch should follow it. A branch that hits here can be redirected at fetch, with no bubble. A branch that misses costs one delay slot while decode works out its target.

Entries are created from the decode stage the first time a direct branch or jump is seen. Indirect jumps are offered on the same port but never stored. The initial direction comes from a static guess: a backward target means taken, and a forward target means not-taken. A branch that jumps to its own address is also treated as not-taken, because such loops are usually error traps that never fire.

The outcome of each branch is reported from the last pipeline stage. It moves a saturating two-bit counter in the matching entry. The buffer is direct-mapped. The low address bits pick the entry, and the remaining high bits are kept as a tag.

Top module: `btb_predictor`

## Requirements
- R1: After reset no entry is valid. Every lookup reports `lk_hit`=0, `lk_taken`=0 and `lk_target`=0.
- R2: A lookup is combinational. When the entry selected by `lk_pc[3:0]` is valid and its stored tag equals `lk_pc[15:4]`, `lk_hit` is 1 and `lk_target` is the stored target in the same cycle.
- R3: On a miss, including a valid entry whose tag differs, `lk_hit`, `lk_taken` and `lk_target` are all 0.
- R4: A direct allocation whose target is below its own address creates an entry with counter 2'b10, so a following lookup reports `lk_taken`=1.
- R5: A direct allocation whose target is above its own address creates an entry with counter 2'b01, so `lk_taken`=0.
- R6: A direct allocation whose target equals its own address creates an entry with counter 2'b01, so `lk_taken`=0.
- R7: An allocation with `al_indirect`=1 changes no entry.
- R8: An allocation for an address that already has a matching valid entry leaves that entry, including its target and counter, unchanged.
- R9: An allocation whose index holds a valid entry with a different tag replaces that entry.
- R10: A resolve that matches an entry moves its counter up by one on taken and down by one on not-taken, saturating at 2'b11 and 2'b00. `lk_taken` is the counter's high bit.
- R11: A resolve whose address has no matching entry changes nothing.
- R12: When an allocation and a resolve target the same index in the same cycle, the allocation wins and the resolve is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 16 | Fetch address looked up this cycle |
| lk_hit | output | 1 | A matching entry exists |
| lk_taken | output | 1 | The matching entry predicts taken |
| lk_target | output | 16 | Predicted target, zero on a miss |
| al_valid | input | 1 | Decode presents a branch or jump |
| al_indirect | input | 1 | The presented jump is indirect and must not be stored |
| al_pc | input | 16 | Address of the decoded branch |
| al_target | input | 16 | Decoded target address |
| rs_valid | input | 1 | A branch resolved this cycle |
| rs_pc | input | 16 | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction |
| rs_mispredict | input | 1 | The fetch-time prediction for this branch was wrong; it is carried for checking and does not alter state |

## Verification
The checker assumes the resolve stage reports its mispredict flag consistently. For a resolve that matches an entry, the flag must equal the difference between that entry's predicted direction and the actual outcome. The bench keeps within this rule because it derives the flag from its own model of the counters, not from the design. The stability checks on indirect, duplicate and unmatched requests only apply in cycles where the other write port is idle. The bench issues those cases alone, and it exercises the mixed case, where both ports target one index, separately.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int ADDR_W  = 16;
    localparam int IDX_W   = 4;
    localparam int TAG_W   = ADDR_W - IDX_W;
    localparam int ENTRIES = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        DIR_STRONG_NT = 2'b00,
        DIR_WEAK_NT   = 2'b01,
        DIR_WEAK_T    = 2'b10,
        DIR_STRONG_T  = 2'b11
    } dir_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        addr_t target;
        dir_t  dir;
    } slot_t;

    function automatic idx_t slot_of(addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction

    // First-sight guess: only a strictly backward target starts as taken.
    function automatic dir_t first_guess(addr_t pc, addr_t tgt);
        return (tgt < pc) ? DIR_WEAK_T : DIR_WEAK_NT;
    endfunction

    function automatic dir_t dir_step(dir_t d, logic taken);
        dir_t r;
        r = d;
        unique case (d)
            DIR_STRONG_NT: r = taken ? DIR_WEAK_NT  : DIR_STRONG_NT;
            DIR_WEAK_NT:   r = taken ? DIR_WEAK_T   : DIR_STRONG_NT;
            DIR_WEAK_T:    r = taken ? DIR_STRONG_T : DIR_WEAK_NT;
            DIR_STRONG_T:  r = taken ? DIR_STRONG_T : DIR_WEAK_T;
            default:       r = d;
        endcase
        return r;
    endfunction

    function automatic logic slot_matches(slot_t s, addr_t a);
        return s.valid && (s.tag == tag_of(a));
    endfunction
endpackage

// File: rtl/btb_alloc_rule.sv
module btb_alloc_rule
    import btb_pkg::*;
(
    input  logic  req,
    input  logic  indirect,
    input  addr_t pc,
    input  addr_t target,
    input  slot_t cur,
    output logic  present,
    output logic  wr_en,
    output slot_t wr_slot
);
    always_comb begin
        present        = slot_matches(cur, pc);
        wr_en          = req && !indirect && !present;
        wr_slot.valid  = 1'b1;
        wr_slot.tag    = tag_of(pc);
        wr_slot.target = target;
        wr_slot.dir    = first_guess(pc, target);
    end
endmodule

// File: rtl/btb_resolve_rule.sv
module btb_resolve_rule
    import btb_pkg::*;
(
    input  logic  req,
    input  addr_t pc,
    input  logic  taken,
    input  slot_t cur,
    output logic  hit,
    output logic  pred,
    output logic  wr_en,
    output dir_t  wr_dir
);
    always_comb begin
        hit    = slot_matches(cur, pc);
        pred   = cur.dir[1];
        wr_en  = req && hit;
        wr_dir = dir_step(cur.dir, taken);
    end
endmodule

// File: rtl/btb_slot_array.sv
module btb_slot_array
    import btb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  idx_t                 lk_idx,
    input  idx_t                 al_idx,
    input  idx_t                 rs_idx,
    input  logic                 al_we,
    input  slot_t                al_slot,
    input  logic                 rs_we,
    input  dir_t                 rs_dir,
    output slot_t                lk_slot,
    output slot_t                al_slot_rd,
    output slot_t                rs_slot_rd,
    output logic [ENTRIES-1:0]   valid_vec,
    output logic [2*ENTRIES-1:0] dir_vec
);
    slot_t slots [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slot_t q;
        logic  al_sel;
        logic  rs_sel;

        assign al_sel = al_we && (al_idx == idx_t'(g));
        assign rs_sel = rs_we && (rs_idx == idx_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (al_sel) begin
                q <= al_slot;
            end else if (rs_sel) begin
                q.dir <= rs_dir;
            end
        end

        assign slots[g]           = q;
        assign valid_vec[g]       = q.valid;
        assign dir_vec[2*g +: 2]  = q.dir;
    end

    assign lk_slot    = slots[lk_idx];
    assign al_slot_rd = slots[al_idx];
    assign rs_slot_rd = slots[rs_idx];
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              al_valid,
    input  logic              al_indirect,
    input  logic [ADDR_W-1:0] al_pc,
    input  logic [ADDR_W-1:0] al_target,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    input  logic              rs_mispredict
);
    slot_t                lk_slot;
    slot_t                al_cur;
    slot_t                rs_cur;
    slot_t                al_new;
    logic                 al_we;
    logic                 al_match;
    logic                 rs_we;
    logic                 rs_hit;
    logic                 rs_pred;
    dir_t                 rs_dir;
    logic [ENTRIES-1:0]   valid_vec;
    logic [2*ENTRIES-1:0] dir_vec;
    logic                 unused_mispredict;

    // The flag only feeds the bound checker.
    assign unused_mispredict = rs_mispredict;

    btb_alloc_rule u_alloc (
        .req     (al_valid),
        .indirect(al_indirect),
        .pc      (al_pc),
        .target  (al_target),
        .cur     (al_cur),
        .present (al_match),
        .wr_en   (al_we),
        .wr_slot (al_new)
    );

    btb_resolve_rule u_resolve (
        .req   (rs_valid),
        .pc    (rs_pc),
        .taken (rs_taken),
        .cur   (rs_cur),
        .hit   (rs_hit),
        .pred  (rs_pred),
        .wr_en (rs_we),
        .wr_dir(rs_dir)
    );

    btb_slot_array u_array (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (slot_of(lk_pc)),
        .al_idx    (slot_of(al_pc)),
        .rs_idx    (slot_of(rs_pc)),
        .al_we     (al_we),
        .al_slot   (al_new),
        .rs_we     (rs_we),
        .rs_dir    (rs_dir),
        .lk_slot   (lk_slot),
        .al_slot_rd(al_cur),
        .rs_slot_rd(rs_cur),
        .valid_vec (valid_vec),
        .dir_vec   (dir_vec)
    );

    always_comb begin
        lk_hit    = slot_matches(lk_slot, lk_pc);
        lk_taken  = lk_hit && lk_slot.dir[1];
        lk_target = lk_hit ? lk_slot.target : '0;
    end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk
    import btb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 lk_hit,
    input logic                 lk_taken,
    input logic [ADDR_W-1:0]    lk_target,
    input logic                 al_valid,
    input logic                 al_indirect,
    input logic                 al_match,
    input logic                 rs_valid,
    input logic                 rs_taken,
    input logic                 rs_mispredict,
    input logic                 rs_hit,
    input logic                 rs_pred,
    input logic [ENTRIES-1:0]   valid_vec,
    input logic [2*ENTRIES-1:0] dir_vec
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_hit && valid_vec == '0));

    assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_taken && lk_target == '0));

    assert_indirect_noop_R7: assert property (@(posedge clk) disable iff (rst)
        (al_valid && al_indirect && !rs_valid) |=> ($stable(valid_vec) && $stable(dir_vec)));

    assert_present_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (al_valid && al_match && !rs_valid) |=> ($stable(valid_vec) && $stable(dir_vec)));

    assert_flag_agrees_R10: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_hit) |-> (rs_mispredict == (rs_pred != rs_taken)));

    assert_unmatched_noop_R11: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_hit && !al_valid) |=> ($stable(valid_vec) && $stable(dir_vec)));
endmodule

bind btb_predictor btb_predictor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .lk_hit       (lk_hit),
    .lk_taken     (lk_taken),
    .lk_target    (lk_target),
    .al_valid     (al_valid),
    .al_indirect  (al_indirect),
    .al_match     (al_match),
    .rs_valid     (rs_valid),
    .rs_taken     (rs_taken),
    .rs_mispredict(rs_mispredict),
    .rs_hit       (rs_hit),
    .rs_pred      (rs_pred),
    .valid_vec    (valid_vec),
    .dir_vec      (dir_vec)
);

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lk_pc = '0;
    logic        lk_hit;
    logic        lk_taken;
    logic [15:0] lk_target;
    logic        al_valid = 1'b0;
    logic        al_indirect = 1'b0;
    logic [15:0] al_pc = '0;
    logic [15:0] al_target = '0;
    logic        rs_valid = 1'b0;
    logic [15:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic        rs_mispredict = 1'b0;

    int checks = 0;
    int errors = 0;

    logic        m_valid [16];
    logic [11:0] m_tag   [16];
    logic [15:0] m_tgt   [16];
    logic [1:0]  m_ctr   [16];

    always #4 clk = ~clk;

    btb_predictor u0 (
        .clk(clk), .rst(rst),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .al_valid(al_valid), .al_indirect(al_indirect), .al_pc(al_pc), .al_target(al_target),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_mispredict(rs_mispredict)
    );

    function automatic logic [15:0] pc_of(int tag, int idx);
        return 16'((tag << 4) | idx);
    endfunction

    task automatic step(input logic av, input logic ai, input logic [15:0] ap, input logic [15:0] at,
                        input logic rv, input logic [15:0] rp, input logic rt);
        int   ri;
        int   wi;
        logic rhit;
        @(negedge clk);
        ri   = int'(rp[3:0]);
        rhit = m_valid[ri] && (m_tag[ri] == rp[15:4]);
        al_valid = av; al_indirect = ai; al_pc = ap; al_target = at;
        rs_valid = rv; rs_pc = rp; rs_taken = rt;
        rs_mispredict = rv && (rhit ? (m_ctr[ri][1] != rt) : rt);
        @(posedge clk);
        #1;
        al_valid = 1'b0; rs_valid = 1'b0; rs_mispredict = 1'b0; al_indirect = 1'b0;
        if (rv && rhit) begin
            if (rt) m_ctr[ri] = (m_ctr[ri] == 2'd3) ? 2'd3 : 2'(m_ctr[ri] + 2'd1);
            else    m_ctr[ri] = (m_ctr[ri] == 2'd0) ? 2'd0 : 2'(m_ctr[ri] - 2'd1);
        end
        if (av && !ai) begin
            wi = int'(ap[3:0]);
            if (!(m_valid[wi] && m_tag[wi] == ap[15:4])) begin
                m_valid[wi] = 1'b1;
                m_tag[wi]   = ap[15:4];
                m_tgt[wi]   = at;
                m_ctr[wi]   = (at < ap) ? 2'd2 : 2'd1;
            end
        end
    endtask

    task automatic look(input logic [15:0] pc, input string req);
        int          i;
        logic        eh;
        logic        et;
        logic [15:0] eg;
        lk_pc = pc;
        #1;
        i  = int'(pc[3:0]);
        eh = m_valid[i] && (m_tag[i] == pc[15:4]);
        et = eh && m_ctr[i][1];
        eg = eh ? m_tgt[i] : 16'h0;
        checks++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
            errors++;
            $display("FAIL %s pc=%h actual hit=%b taken=%b target=%h expected hit=%b taken=%b target=%h",
                     req, pc, lk_hit, lk_taken, lk_target, eh, et, eg);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual run still busy, expected finish within 50000 cycles");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset, every index
        for (int i = 0; i < 16; i++) look(pc_of(12'h3A0, i), "R1");

        // R4 R5 R6 with R2: fill every index, kind chosen by index
        for (int i = 0; i < 16; i++) begin
            logic [15:0] p;
            p = pc_of(12'h3A0, i);
            case (i % 3)
                0: step(1'b1, 1'b0, p, p - 16'd20, 1'b0, 16'h0, 1'b0);
                1: step(1'b1, 1'b0, p, p + 16'd7,  1'b0, 16'h0, 1'b0);
                default: step(1'b1, 1'b0, p, p, 1'b0, 16'h0, 1'b0);
            endcase
            case (i % 3)
                0: look(p, "R2 R4");
                1: look(p, "R2 R5");
                default: look(p, "R2 R6");
            endcase
        end

        // R3: aliases with a different tag miss
        for (int i = 0; i < 16; i += 5) look(pc_of(12'h155, i), "R3");

        // R7: indirect allocation on an alias of index 0
        step(1'b1, 1'b1, pc_of(12'h155, 0), 16'h1234, 1'b0, 16'h0, 1'b0);
        look(pc_of(12'h155, 0), "R7");
        look(pc_of(12'h3A0, 0), "R7");

        // R8: duplicate allocation keeps old target and counter
        step(1'b1, 1'b0, pc_of(12'h3A0, 7), 16'h0001, 1'b0, 16'h0, 1'b0);
        look(pc_of(12'h3A0, 7), "R8");

        // R10: counter walk per entry, up to saturation then down to saturation
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 9; k++) begin
                step(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, pc_of(12'h3A0, i), (k < 4 || k == 8));
                look(pc_of(12'h3A0, i), "R10");
            end
        end

        // R11: resolve on an unmatched alias
        step(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, pc_of(12'h2B2, 9), 1'b1);
        look(pc_of(12'h3A0, 9), "R11");
        step(1'b0, 1'b0, 16'h0, 16'h0, 1'b1, pc_of(12'h2B2, 9), 1'b0);
        look(pc_of(12'h3A0, 9), "R11");
        look(pc_of(12'h2B2, 9), "R11");

        // R9: replacement of a different tag
        step(1'b1, 1'b0, pc_of(12'h7C1, 3), 16'h0100, 1'b0, 16'h0, 1'b0);
        look(pc_of(12'h7C1, 3), "R9");
        look(pc_of(12'h3A0, 3), "R9");

        // R12: allocation and resolve on index 5 in one cycle
        step(1'b1, 1'b0, pc_of(12'h044, 5), 16'hF000, 1'b1, pc_of(12'h3A0, 5), 1'b1);
        look(pc_of(12'h044, 5), "R12");
        look(pc_of(12'h3A0, 5), "R12");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule